// File: doc/BRIEF.md
# Low-Power Timekeeper with Cross-Domain Register Writes

This peripheral keeps time in a 47-bit count that advances once per edge of a slow low-power clock (nominally 32 kHz). The count is presented to software as a 32-bit whole-seconds word and a 15-bit fraction word. A second 47-bit value, written in the same two-word form, is compared with the count on every slow edge. When the two are equal, an alarm flag is raised. The slow domain also holds a run control bit, a sticky non-valid bit that is set on reset, and a sticky violation bit that an external detector sets.

Software uses a simple 32-bit strobe bus on the fast clock. Every write to the timekeeping, control or status words is held stable and carried into the slow domain by a toggle handshake. A single return channel then carries back a coherent snapshot of all slow-domain state together with the write acknowledgement. While a write is in flight the status word shows it as busy. A second write that arrives in that window is discarded and raises a write-error flag. Completion raises a write-complete flag, which the next status read clears. The interrupt-enable word is the only register written directly at bus speed, and it never takes part in the handshake. The single interrupt output is the OR of each enabled status flag.

Top module: `lp_rtc`

## Requirements
- R1: After reset, the status word reads 0x202 (the idle/next-write bit 9 and the non-valid bit 1 are set). The seconds, fraction, control and interrupt-enable words read 0. The alarm reads seconds 0xFFFFFFFF and fraction 0x7FFF. The interrupt output is low.
- R2: A write to any of offsets 0x00, 0x04, 0x08, 0x0C, 0x10 or 0x14 sets status bit 10 (busy) and clears bit 9 until the slow domain has applied it. Completion sets status bit 8 (write complete), and the written value can then be read back.
- R3: A status read (offset 0x14) returns bit 8 and clears it in the same cycle. A following read shows it as 0.
- R4: A handshaked write that arrives while bit 10 is set is discarded and sets status bit 7 (write error). The registers keep their previous values.
- R5: A write to the interrupt-enable word (offset 0x18) takes effect on the next cycle. Only bits 9, 8, 7 and 4 are kept. The write does not set bit 10 or bit 8.
- R6: The count stays still until the seconds word has been written at least once, even with control bit 3 (run) set. Once seeded and enabled, it advances.
- R7: With control bit 3 clear, a seeded count holds its value.
- R8: When the count equals the alarm value, status bit 4 (alarm) is set.
- R9: Writing 1 to status bit 7, 4, 1 or 0 clears that flag when the write completes. Writing 0 to a flag's bit leaves that flag unchanged.
- R10: The interrupt output is high exactly when some status bit among 9, 8, 7 and 4 is set together with the interrupt-enable bit at the same position.
- R11: A pulse on the violation input sets status bit 0, and the bit stays set until software clears it.
- R12: The fraction is the low 15 bits of one 47-bit count, so overflow of the fraction carries into the seconds word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus-side fast clock |
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| lp_clk | input | 1 | Slow low-power clock; the count advances on each of its edges |
| viol_i | input | 1 | Violation detector pulse, synchronous to lp_clk |
| bus_wr | input | 1 | Write strobe, one fast cycle |
| bus_rd | input | 1 | Read strobe, one fast cycle |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| irq | output | 1 | Interrupt, OR of the enabled status flags |

## Verification
The bus side sees all slow-domain state through a mirrored snapshot. A wrong handshake state therefore shows up at the ports within one round trip, which is about ten slow-clock edges: the busy bit never falls, write-complete never rises, or a read-back value differs from what was written. A broken write-error path shows up on the very next status read after a write collides with one already in flight. The interrupt output depends on registered flags and enables with no added delay, so an enable or masking fault is visible one fast cycle after the enable word is written. Counter and alarm faults appear as a wrong seconds word or a missing alarm bit tens of slow edges after counting starts.

// File: rtl/lpr_pkg.sv
package lpr_pkg;
   localparam int OFS_SEC   = 'h00;
   localparam int OFS_FRAC  = 'h04;
   localparam int OFS_ASEC  = 'h08;
   localparam int OFS_AFRAC = 'h0C;
   localparam int OFS_CTRL  = 'h10;
   localparam int OFS_STAT  = 'h14;
   localparam int OFS_IEN   = 'h18;

   localparam int B_BUSY = 10;
   localparam int B_NEXT = 9;
   localparam int B_DONE = 8;
   localparam int B_ERR  = 7;
   localparam int B_ALM  = 4;
   localparam int B_RUN  = 3;
   localparam int B_NVAL = 1;
   localparam int B_VIOL = 0;

   localparam logic [31:0] IEN_MASK = (32'd1 << B_NEXT) | (32'd1 << B_DONE) |
                                      (32'd1 << B_ERR)  | (32'd1 << B_ALM);

   typedef enum logic [2:0] {
      SEL_SEC, SEL_FRAC, SEL_ASEC, SEL_AFRAC, SEL_CTRL, SEL_STAT, SEL_IEN, SEL_NONE
   } reg_sel_e;

   function automatic reg_sel_e lpr_decode(input logic [7:0] a);
      case (a)
         8'(OFS_SEC):   return SEL_SEC;
         8'(OFS_FRAC):  return SEL_FRAC;
         8'(OFS_ASEC):  return SEL_ASEC;
         8'(OFS_AFRAC): return SEL_AFRAC;
         8'(OFS_CTRL):  return SEL_CTRL;
         8'(OFS_STAT):  return SEL_STAT;
         8'(OFS_IEN):   return SEL_IEN;
         default:       return SEL_NONE;
      endcase
   endfunction
endpackage

// File: rtl/lpr_sync.sv
module lpr_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] sh_q;

   generate
      if (STAGES == 2) begin : g_pair
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= '0;
            else        sh_q <= {sh_q[0], d};
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= '0;
            else        sh_q <= {sh_q[STAGES-2:0], d};
         end
      end
   endgenerate

   assign q = sh_q[STAGES-1];
endmodule

// File: rtl/lpr_lp_core.sv
module lpr_lp_core
   import lpr_pkg::*;
#(
   parameter int SEC_W  = 32,
   parameter int FRAC_W = 15,
   parameter int SYNC   = 2,
   localparam int CNT_W = SEC_W + FRAC_W,
   localparam int PAY_W = 1 + 2*CNT_W + 4
) (
   input  logic             lp_clk,
   input  logic             rst_n,
   input  logic             viol_i,
   input  logic             req_tog_i,
   input  reg_sel_e         req_sel_i,
   input  logic [31:0]      req_data_i,
   input  logic             rtn_ack_i,
   output logic             rtn_tog_o,
   output logic [PAY_W-1:0] rtn_pay_o,
   output logic [CNT_W-1:0] count_o,
   output logic             run_o,
   output logic             apply_o
);
   localparam logic [PAY_W-1:0] PAY_RST =
      {1'b0, {CNT_W{1'b0}}, {CNT_W{1'b1}}, 4'b0010};

   logic             req_s, seen_q, ack_s;
   logic [CNT_W-1:0] count_q, count_nxt, alarm_q;
   logic             run_en_q, seeded_q, caf_q, nvf_q, svf_q, run;
   logic             hit_sec, hit_frac, hit_asec, hit_afrac, hit_ctrl, hit_stat;

   lpr_sync #(.STAGES(SYNC)) u_req_sync (.clk(lp_clk), .rst_n(rst_n), .d(req_tog_i), .q(req_s));
   lpr_sync #(.STAGES(SYNC)) u_ack_sync (.clk(lp_clk), .rst_n(rst_n), .d(rtn_ack_i), .q(ack_s));

   assign apply_o   = req_s != seen_q;
   assign hit_sec   = apply_o && req_sel_i == SEL_SEC;
   assign hit_frac  = apply_o && req_sel_i == SEL_FRAC;
   assign hit_asec  = apply_o && req_sel_i == SEL_ASEC;
   assign hit_afrac = apply_o && req_sel_i == SEL_AFRAC;
   assign hit_ctrl  = apply_o && req_sel_i == SEL_CTRL;
   assign hit_stat  = apply_o && req_sel_i == SEL_STAT;
   assign run       = run_en_q && seeded_q;

   always_comb begin
      count_nxt = count_q;
      if (run)      count_nxt = count_q + 1'b1;
      if (hit_sec)  count_nxt[CNT_W-1:FRAC_W] = req_data_i[SEC_W-1:0];
      if (hit_frac) count_nxt[FRAC_W-1:0]     = req_data_i[FRAC_W-1:0];
   end

   always_ff @(posedge lp_clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_q   <= 1'b0;
         count_q  <= '0;
         alarm_q  <= '1;
         run_en_q <= 1'b0;
         seeded_q <= 1'b0;
         caf_q    <= 1'b0;
         nvf_q    <= 1'b1;
         svf_q    <= 1'b0;
      end else begin
         seen_q  <= req_s;
         count_q <= count_nxt;
         if (hit_sec)   seeded_q <= 1'b1;
         if (hit_asec)  alarm_q[CNT_W-1:FRAC_W] <= req_data_i[SEC_W-1:0];
         if (hit_afrac) alarm_q[FRAC_W-1:0]     <= req_data_i[FRAC_W-1:0];
         if (hit_ctrl)  run_en_q <= req_data_i[B_RUN];
         if (hit_stat) begin
            if (req_data_i[B_ALM])  caf_q <= 1'b0;
            if (req_data_i[B_NVAL]) nvf_q <= 1'b0;
            if (req_data_i[B_VIOL]) svf_q <= 1'b0;
         end
         if (count_q == alarm_q) caf_q <= 1'b1;
         if (viol_i)             svf_q <= 1'b1;
      end
   end

   always_ff @(posedge lp_clk or negedge rst_n) begin
      if (!rst_n) begin
         rtn_tog_o <= 1'b0;
         rtn_pay_o <= PAY_RST;
      end else if (ack_s == rtn_tog_o) begin
         rtn_pay_o <= {seen_q, count_q, alarm_q, run_en_q, caf_q, nvf_q, svf_q};
         rtn_tog_o <= ~rtn_tog_o;
      end
   end

   assign count_o = count_q;
   assign run_o   = run;
endmodule

// File: rtl/lpr_bus_if.sv
module lpr_bus_if
   import lpr_pkg::*;
#(
   parameter int SEC_W  = 32,
   parameter int FRAC_W = 15,
   parameter int ADDR_W = 5,
   parameter int SYNC   = 2,
   localparam int CNT_W = SEC_W + FRAC_W,
   localparam int PAY_W = 1 + 2*CNT_W + 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic              rd_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [31:0]       wdata_i,
   output logic [31:0]       rdata_o,
   output logic              irq_o,
   output logic              req_tog_o,
   output reg_sel_e          req_sel_o,
   output logic [31:0]       req_data_o,
   input  logic              rtn_tog_i,
   input  logic [PAY_W-1:0]  rtn_pay_i,
   output logic              rtn_ack_o,
   output logic              busy_o,
   output logic              done_o,
   output logic              wcf_o,
   output logic              wef_o,
   output logic [31:0]       ier_o
);
   localparam logic [PAY_W-1:0] PAY_RST =
      {1'b0, {CNT_W{1'b0}}, {CNT_W{1'b1}}, 4'b0010};

   logic [PAY_W-1:0] mir_q;
   logic             rtn_s, new_pay, sync_wr, clr_err_q;
   logic [31:0]      ier_q, stat_w, rd_w;
   logic [CNT_W-1:0] m_count, m_alarm;
   reg_sel_e         sel;

   lpr_sync #(.STAGES(SYNC)) u_rtn_sync (.clk(clk), .rst_n(rst_n), .d(rtn_tog_i), .q(rtn_s));

   assign sel     = lpr_decode(8'(addr_i));
   assign new_pay = rtn_s != rtn_ack_o;
   assign busy_o  = req_tog_o != mir_q[PAY_W-1];
   assign done_o  = new_pay && busy_o && (rtn_pay_i[PAY_W-1] == req_tog_o);
   assign sync_wr = wr_i && sel != SEL_IEN && sel != SEL_NONE;
   assign m_count = mir_q[4+CNT_W +: CNT_W];
   assign m_alarm = mir_q[4 +: CNT_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mir_q     <= PAY_RST;
         rtn_ack_o <= 1'b0;
      end else if (new_pay) begin
         mir_q     <= rtn_pay_i;
         rtn_ack_o <= rtn_s;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_tog_o  <= 1'b0;
         req_sel_o  <= SEL_NONE;
         req_data_o <= '0;
         clr_err_q  <= 1'b0;
         wcf_o      <= 1'b0;
         wef_o      <= 1'b0;
         ier_q      <= '0;
      end else begin
         if (sync_wr && !busy_o) begin
            req_tog_o  <= ~req_tog_o;
            req_sel_o  <= sel;
            req_data_o <= wdata_i;
            clr_err_q  <= sel == SEL_STAT && wdata_i[B_ERR];
         end
         if (rd_i && sel == SEL_STAT) wcf_o <= 1'b0;
         if (done_o)                  wcf_o <= 1'b1;
         if (done_o && clr_err_q)     wef_o <= 1'b0;
         if (sync_wr && busy_o)       wef_o <= 1'b1;
         if (wr_i && sel == SEL_IEN)  ier_q <= wdata_i & IEN_MASK;
      end
   end

   always_comb begin
      stat_w         = '0;
      stat_w[B_BUSY] = busy_o;
      stat_w[B_NEXT] = !busy_o;
      stat_w[B_DONE] = wcf_o;
      stat_w[B_ERR]  = wef_o;
      stat_w[B_ALM]  = mir_q[2];
      stat_w[B_NVAL] = mir_q[1];
      stat_w[B_VIOL] = mir_q[0];
   end

   always_comb begin
      rd_w = '0;
      case (sel)
         SEL_SEC:   rd_w[SEC_W-1:0]  = m_count[CNT_W-1:FRAC_W];
         SEL_FRAC:  rd_w[FRAC_W-1:0] = m_count[FRAC_W-1:0];
         SEL_ASEC:  rd_w[SEC_W-1:0]  = m_alarm[CNT_W-1:FRAC_W];
         SEL_AFRAC: rd_w[FRAC_W-1:0] = m_alarm[FRAC_W-1:0];
         SEL_CTRL:  rd_w[B_RUN]      = mir_q[3];
         SEL_STAT:  rd_w             = stat_w;
         SEL_IEN:   rd_w             = ier_q;
         default:   rd_w             = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    rdata_o <= '0;
      else if (rd_i) rdata_o <= rd_w;
   end

   assign irq_o = |(ier_q & stat_w);
   assign ier_o = ier_q;
endmodule

// File: rtl/lp_rtc.sv
module lp_rtc
   import lpr_pkg::*;
#(
   parameter int SEC_W       = 32,
   parameter int FRAC_W      = 15,
   parameter int ADDR_W      = 5,
   parameter int SYNC_STAGES = 2,
   localparam int CNT_W      = SEC_W + FRAC_W,
   localparam int PAY_W      = 1 + 2*CNT_W + 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lp_clk,
   input  logic              viol_i,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              irq
);
   generate
      if (SEC_W < 1 || SEC_W > 32) begin : g_bad_sec
         $error("lp_rtc: SEC_W must lie in 1..32");
      end
      if (FRAC_W < 1 || FRAC_W > 32) begin : g_bad_frac
         $error("lp_rtc: FRAC_W must lie in 1..32");
      end
      if (ADDR_W < 5 || ADDR_W > 8) begin : g_bad_addr
         $error("lp_rtc: ADDR_W must lie in 5..8");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("lp_rtc: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic             req_tog, rtn_tog, rtn_ack;
   reg_sel_e         req_sel;
   logic [31:0]      req_data, ier;
   logic [PAY_W-1:0] rtn_pay;
   logic             bus_busy, wr_done, wcf, wef, lp_run, lp_apply;
   logic [CNT_W-1:0] lp_count;

   lpr_bus_if #(.SEC_W(SEC_W), .FRAC_W(FRAC_W), .ADDR_W(ADDR_W), .SYNC(SYNC_STAGES)) u_bus (
      .clk(clk), .rst_n(rst_n), .wr_i(bus_wr), .rd_i(bus_rd), .addr_i(bus_addr),
      .wdata_i(bus_wdata), .rdata_o(bus_rdata), .irq_o(irq),
      .req_tog_o(req_tog), .req_sel_o(req_sel), .req_data_o(req_data),
      .rtn_tog_i(rtn_tog), .rtn_pay_i(rtn_pay), .rtn_ack_o(rtn_ack),
      .busy_o(bus_busy), .done_o(wr_done), .wcf_o(wcf), .wef_o(wef), .ier_o(ier)
   );

   lpr_lp_core #(.SEC_W(SEC_W), .FRAC_W(FRAC_W), .SYNC(SYNC_STAGES)) u_lp (
      .lp_clk(lp_clk), .rst_n(rst_n), .viol_i(viol_i),
      .req_tog_i(req_tog), .req_sel_i(req_sel), .req_data_i(req_data),
      .rtn_ack_i(rtn_ack), .rtn_tog_o(rtn_tog), .rtn_pay_o(rtn_pay),
      .count_o(lp_count), .run_o(lp_run), .apply_o(lp_apply)
   );
endmodule

// File: rtl/lp_rtc_chk.sv
module lp_rtc_chk
   import lpr_pkg::*;
#(
   parameter int CNT_W  = 47,
   parameter int ADDR_W = 5
) (
   input logic              clk,
   input logic              lp_clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic              bus_rd,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              irq,
   input logic              busy,
   input logic              done,
   input logic              wcf,
   input logic              wef,
   input logic [31:0]       ier,
   input logic [CNT_W-1:0]  count,
   input logic              run,
   input logic              apply
);
   reg_sel_e sel;
   logic     hs_wr;
   assign sel   = lpr_decode(8'(bus_addr));
   assign hs_wr = bus_wr && sel != SEL_IEN && sel != SEL_NONE;

   // R2: completion raises the write-complete flag
   a_r2_done_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> wcf);

   // R2: busy only falls through a completion
   a_r2_busy_until_done: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> busy);

   // R3: a status read without a coincident completion leaves the flag clear
   a_r3_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && sel == SEL_STAT && !done) |=> !wcf);

   // R4: colliding write raises the error flag
   a_r4_drop_flags_err: assert property (@(posedge clk) disable iff (!rst_n)
      (hs_wr && busy) |=> wef);

   // R5: enable writes never start a crossing
   a_r5_ien_no_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && sel == SEL_IEN && !busy) |=> !busy);

   // R10: with every source masked the output stays low
   a_r10_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
      (ier == 32'd0) |-> !irq);

   // R6, R7: a stopped counter holds unless a write lands
   a_r6_stopped_holds: assert property (@(posedge lp_clk) disable iff (!rst_n)
      (!run && !apply) |=> $stable(count));
endmodule

bind lp_rtc lp_rtc_chk #(.CNT_W(SEC_W + FRAC_W), .ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .lp_clk(lp_clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
   .bus_addr(bus_addr), .irq(irq), .busy(bus_busy), .done(wr_done), .wcf(wcf),
   .wef(wef), .ier(ier), .count(lp_count), .run(lp_run), .apply(lp_apply)
);

// File: tb/lp_rtc_tb.sv
module lp_rtc_tb;
   import lpr_pkg::*;

   logic        clk = 1'b0, lp_clk = 1'b0, rst_n = 1'b0, viol = 1'b0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq;

   always #4  clk    = ~clk;
   always #28 lp_clk = ~lp_clk;

   lp_rtc u_dut (
      .clk(clk), .rst_n(rst_n), .lp_clk(lp_clk), .viol_i(viol),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
   );

   typedef struct {
      logic [31:0] exp;
      logic [31:0] mask;
      string       tag;
   } exp_t;

   exp_t sb[$];
   int   total = 0, bad = 0;
   logic chk_flag = 1'b0, chk_pend = 1'b0;

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, got, exp);
      end
   endtask

   // monitor: pops one expectation per checked read
   always @(posedge clk) chk_pend <= bus_rd && chk_flag;
   always @(negedge clk) begin
      exp_t e;
      if (chk_pend) begin
         if (sb.size() == 0) begin
            total++; bad++;
            $display("FAIL scoreboard underflow actual=%h expected=none", bus_rdata);
         end else begin
            e = sb.pop_front();
            check(e.tag, bus_rdata & e.mask, e.exp & e.mask);
         end
      end
   end

   task automatic rd_exp(input int a, input logic [31:0] exp, input logic [31:0] mask,
                         input string tag);
      sb.push_back('{exp, mask, tag});
      @(posedge clk); #1;
      bus_rd = 1'b1; chk_flag = 1'b1; bus_addr = 5'(a);
      @(posedge clk); #1;
      bus_rd = 1'b0; chk_flag = 1'b0;
   endtask

   task automatic rd_raw(input int a, output logic [31:0] v);
      @(posedge clk); #1;
      bus_rd = 1'b1; bus_addr = 5'(a);
      @(posedge clk); #1;
      bus_rd = 1'b0; v = bus_rdata;
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      @(posedge clk); #1;
      bus_wr = 1'b1; bus_addr = 5'(a); bus_wdata = d;
      @(posedge clk); #1;
      bus_wr = 1'b0;
   endtask

   task automatic wait_idle(output logic [31:0] dsr);
      logic [31:0] v;
      v = 32'h400;
      for (int i = 0; i < 1000 && v[B_BUSY]; i++) rd_raw(OFS_STAT, v);
      if (v[B_BUSY]) begin
         total++; bad++;
         $display("FAIL R2 busy stuck actual=%h expected=%h", v, 32'h0);
      end
      dsr = v;
   endtask

   task automatic lp_wait(input int n);
      repeat (n) @(posedge lp_clk);
      @(posedge clk);
   endtask

   task automatic chk_irq(input logic exp, input string tag);
      @(negedge clk);
      check(tag, {31'd0, irq}, {31'd0, exp});
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [31:0] d, f1, f2;
      repeat (5) @(posedge clk);
      #1 rst_n = 1'b1;
      repeat (3) @(posedge clk);

      // R1 reset state
      chk_irq(1'b0, "R1 irq after reset");
      rd_exp(OFS_STAT,  32'h202,      32'hFFFF_FFFF, "R1 status");
      rd_exp(OFS_SEC,   32'h0,        32'hFFFF_FFFF, "R1 seconds");
      rd_exp(OFS_IEN,   32'h0,        32'hFFFF_FFFF, "R1 enables");
      rd_exp(OFS_CTRL,  32'h0,        32'hFFFF_FFFF, "R1 control");
      rd_exp(OFS_ASEC,  32'hFFFF_FFFF,32'hFFFF_FFFF, "R1 alarm seconds");
      rd_exp(OFS_AFRAC, 32'h7FFF,     32'hFFFF_FFFF, "R1 alarm fraction");

      // R5 / R10 enable word at bus speed
      wr(OFS_IEN, 32'h0000_FFFF);
      chk_irq(1'b1, "R10 idle bit enabled");
      rd_exp(OFS_IEN, 32'h390, 32'hFFFF_FFFF, "R5 kept bits");
      rd_exp(OFS_STAT, 32'h0, 32'h500, "R5 no busy no complete");
      wr(OFS_IEN, 32'h0);
      chk_irq(1'b0, "R10 all masked");

      // R2 / R3 / R6 enable before seeding
      wr(OFS_CTRL, 32'h8);
      rd_exp(OFS_STAT, 32'h400, 32'h600, "R2 busy during crossing");
      wait_idle(d);
      check("R2 complete flag", d & 32'h100, 32'h100);
      rd_exp(OFS_STAT, 32'h0, 32'h100, "R3 cleared by read");
      lp_wait(20);
      rd_exp(OFS_SEC,  32'h0, 32'hFFFF_FFFF, "R6 unseeded seconds");
      rd_exp(OFS_FRAC, 32'h0, 32'hFFFF_FFFF, "R6 unseeded fraction");
      rd_exp(OFS_CTRL, 32'h8, 32'hFFFF_FFFF, "R2 control readback");
      wr(OFS_CTRL, 32'h0);
      wait_idle(d);

      // R4 collision
      wr(OFS_SEC, 32'h1234);
      wait_idle(d);
      wr(OFS_FRAC, 32'h5);
      wr(OFS_SEC, 32'hBAD);
      wait_idle(d);
      check("R4 error flag", d & 32'h80, 32'h80);
      rd_exp(OFS_SEC,  32'h1234, 32'hFFFF_FFFF, "R4 dropped write");
      rd_exp(OFS_FRAC, 32'h5,    32'hFFFF_FFFF, "R2 fraction readback");

      // R7 seeded but disabled holds
      lp_wait(20);
      rd_exp(OFS_SEC,  32'h1234, 32'hFFFF_FFFF, "R7 seconds held");
      rd_exp(OFS_FRAC, 32'h5,    32'hFFFF_FFFF, "R7 fraction held");

      // R9 / R10 write-error clear
      wr(OFS_IEN, 32'h80);
      chk_irq(1'b1, "R10 error enabled");
      wr(OFS_STAT, 32'h80);
      wait_idle(d);
      check("R9 error cleared", d & 32'h80, 32'h0);
      check("R9 non-valid untouched", d & 32'h2, 32'h2);
      chk_irq(1'b0, "R10 after error clear");
      wr(OFS_STAT, 32'h3);
      wait_idle(d);
      check("R9 non-valid cleared", d & 32'h2, 32'h0);

      // R11 sticky violation
      @(negedge lp_clk) viol = 1'b1;
      @(negedge lp_clk) viol = 1'b0;
      lp_wait(20);
      rd_exp(OFS_STAT, 32'h1, 32'h1, "R11 violation set");
      lp_wait(20);
      rd_exp(OFS_STAT, 32'h1, 32'h1, "R11 violation sticky");
      wr(OFS_STAT, 32'h1);
      wait_idle(d);
      check("R9 violation cleared", d & 32'h1, 32'h0);

      // R8 / R12 alarm across a fraction carry
      wr(OFS_FRAC, 32'h7FFC);  wait_idle(d);
      wr(OFS_SEC, 32'd100);    wait_idle(d);
      wr(OFS_ASEC, 32'd101);   wait_idle(d);
      wr(OFS_AFRAC, 32'd2);    wait_idle(d);
      rd_exp(OFS_ASEC,  32'd101, 32'hFFFF_FFFF, "R2 alarm seconds readback");
      rd_exp(OFS_AFRAC, 32'd2,   32'hFFFF_FFFF, "R2 alarm fraction readback");
      rd_exp(OFS_STAT,  32'h0,   32'h10,        "R8 no alarm before run");
      wr(OFS_IEN, 32'h10);
      wr(OFS_CTRL, 32'h8);     wait_idle(d);
      lp_wait(40);
      rd_exp(OFS_SEC,  32'd101, 32'hFFFF_FFFF, "R12 carry into seconds");
      rd_exp(OFS_STAT, 32'h10,  32'h10,        "R8 alarm flag");
      chk_irq(1'b1, "R8 alarm interrupt");
      rd_raw(OFS_FRAC, f1);
      lp_wait(10);
      rd_raw(OFS_FRAC, f2);
      check("R6 running advances", {31'd0, f2 != f1}, 32'd1);
      wr(OFS_STAT, 32'h10);
      wait_idle(d);
      check("R9 alarm cleared", d & 32'h10, 32'h0);
      chk_irq(1'b0, "R10 after alarm clear");

      repeat (4) @(posedge clk);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule